// File: doc/BRIEF.md
# Selectable-Program-Counter Byte Processor Core

This block is a compact 8-bit processor core with a file of sixteen 16-bit general registers. None of these registers is a dedicated program counter. A 4-bit pointer selects, at run time, which register supplies the next instruction address. A second 4-bit pointer names the register used for indirect addressing. An 8-bit accumulator holds working data, and a one-bit flag records the outcome of a subtraction.

Instructions come in over a byte-wide synchronous read port. The core executes a small subset:

- load immediate
- subtract immediate
- copy the high byte of a register into the accumulator
- write the accumulator into the high or low byte of a register
- switch the active program counter

Every instruction takes two machine cycles, a fetch cycle and an execute cycle. Each machine cycle lasts a fixed number of clocks. An opcode outside the subset halts the core until the next reset.

A debug port exposes any register, the accumulator, the flag and both pointers. A testbench or a surrounding system uses it to confirm the state left behind by start-up code that loads stack, interrupt and interpreter pointers.

Top module: `regsel_core`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the core shows: program-counter pointer 0, indirect pointer 0, register 0 = 0x0000, accumulator 0, flag 0 and `halted` low. On that first clock it issues a read of address 0x0000. The other registers are not initialised.
- R2: A machine cycle lasts CLKS_PER_MC clocks (default 8). `mem_rd_en` is high only on the first clock of a machine cycle that reads memory. `mem_rdata` is valid on the clock after the read. `mc_end` is high on the last clock of every machine cycle. Each supported instruction spans exactly two machine cycles.
- R3: Every opcode fetch reads the address held in the active register and then adds one to that register, wrapping from 0xFFFF to 0x0000.
- R4: Opcode 0x9N copies the upper byte of register N into the accumulator. Opcode 0xBN writes the accumulator into the upper byte of register N. Opcode 0xAN writes the accumulator into the lower byte of register N. The other byte of the register is kept in both write cases.
- R5: Opcode 0xF8 reads the byte that follows it during the execute cycle and loads it into the accumulator. It then advances the active register past that byte.
- R6: Opcode 0xFF reads the following byte during the execute cycle and sets the accumulator to the accumulator minus that byte, modulo 256. It sets the flag to 1 when the accumulator was at least the byte (no borrow), and to 0 otherwise. It then advances the active register past that byte.
- R7: Opcode 0xDN sets the program-counter pointer to N. The next fetch reads the address held in register N.
- R8: Any opcode outside 0x9N, 0xAN, 0xBN, 0xDN, 0xF8 and 0xFF is still fetched and counted. It raises `halted` at the end of its fetch machine cycle. From then until reset there are no further reads, no `mc_end` pulses and no change to registers or the accumulator.
- R9: `dbg_reg` presents register `dbg_sel` one clock after `dbg_sel` is applied. `dbg_d`, `dbg_df`, `dbg_p` and `dbg_x` present the accumulator, the flag and the two pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Read address, taken from the active program-counter register |
| mem_rd_en | output | 1 | Read strobe, first clock of a reading machine cycle |
| mem_rdata | input | 8 | Read data, valid one clock after the strobe |
| dbg_sel | input | 4 | Register index for the debug port |
| dbg_reg | output | 16 | Contents of the selected register, registered |
| dbg_d | output | 8 | Accumulator |
| dbg_df | output | 1 | Borrow flag (1 = no borrow) |
| dbg_p | output | 4 | Program-counter pointer |
| dbg_x | output | 4 | Indirect-address pointer |
| mc_end | output | 1 | High on the last clock of each machine cycle |
| halted | output | 1 | Sticky unsupported-opcode halt |

## Verification
The assertions check the following on every cycle:

- the reset values of the two pointers and the halt flag;
- the exact spacing of machine-cycle ends;
- the single-clock read strobe;
- the one-step advance of the active register after each fetch;
- the stickiness and silence of the halted state.

Only the bench's scenarios can show the data results, because they depend on program content. These cover:

- the accumulator and register bytes written by each opcode;
- the borrow flag at the greater, equal and smaller boundaries;
- fetch continuing from a newly selected register;
- the wrap of a program counter at 0xFFFF;
- the complete register state and the 41-machine-cycle count after a 20-instruction start-up routine followed by an unsupported opcode.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_EXEC,
    ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    K_GHI,
    K_PLO,
    K_PHI,
    K_SEP,
    K_LDI,
    K_SMI,
    K_BAD
  } op_kind_e;

  localparam logic [3:0] HI_GHI  = 4'h9;
  localparam logic [3:0] HI_PLO  = 4'hA;
  localparam logic [3:0] HI_PHI  = 4'hB;
  localparam logic [3:0] HI_SEP  = 4'hD;
  localparam logic [7:0] OPC_LDI = 8'hF8;
  localparam logic [7:0] OPC_SMI = 8'hFF;

endpackage

// File: rtl/regsel_regfile.sv
module regsel_regfile #(
  parameter int NREG  = 16,
  parameter int REG_W = 16,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [SEL_W-1:0] raddr_a,
  input  logic [SEL_W-1:0] raddr_b,
  input  logic [SEL_W-1:0] raddr_dbg,
  output logic [REG_W-1:0] rdata_a,
  output logic [REG_W-1:0] rdata_b,
  output logic [REG_W-1:0] rdata_dbg
);

  // The array has no reset, so it maps onto distributed RAM.
  logic [REG_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  always_ff @(posedge clk) begin
    rdata_dbg <= regs[raddr_dbg];
  end

endmodule

// File: rtl/regsel_decode.sv
module regsel_decode
  import regsel_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind,
  output logic       needs_imm
);

  always_comb begin
    unique case (opcode[7:4])
      HI_GHI:  kind = K_GHI;
      HI_PLO:  kind = K_PLO;
      HI_PHI:  kind = K_PHI;
      HI_SEP:  kind = K_SEP;
      default: begin
        if (opcode == OPC_LDI)      kind = K_LDI;
        else if (opcode == OPC_SMI) kind = K_SMI;
        else                        kind = K_BAD;
      end
    endcase
    needs_imm = (kind == K_LDI) || (kind == K_SMI);
  end

endmodule

// File: rtl/regsel_seq.sv
module regsel_seq
  import regsel_pkg::*;
#(
  parameter int CLKS_PER_MC = 8,
  parameter int CAP_PHASE   = 1,
  localparam int PH_W = $clog2(CLKS_PER_MC)
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  output logic phase_first,
  output logic phase_cap,
  output logic phase_last,
  output logic in_fetch,
  output logic in_exec,
  output logic halted
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_MC - 1);
  localparam logic [PH_W-1:0] PH_CAP  = PH_W'(CAP_PHASE);

  seq_state_e      st_q;
  logic [PH_W-1:0] ph_q;
  logic            run;

  assign run         = (st_q != ST_HALT);
  assign phase_first = run && (ph_q == '0);
  assign phase_cap   = run && (ph_q == PH_CAP);
  assign phase_last  = run && (ph_q == PH_LAST);
  assign in_fetch    = (st_q == ST_FETCH);
  assign in_exec     = (st_q == ST_EXEC);
  assign halted      = !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_FETCH;
      ph_q <= '0;
    end else if (run) begin
      if (ph_q == PH_LAST) begin
        ph_q <= '0;
        if (st_q == ST_FETCH) st_q <= stop ? ST_HALT : ST_EXEC;
        else                  st_q <= ST_FETCH;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/regsel_core.sv
module regsel_core
  import regsel_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int DATA_W      = 8,
  parameter int CLKS_PER_MC = 8,
  localparam int SEL_W = $clog2(NREG),
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [REG_W-1:0]  mem_addr,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [SEL_W-1:0]  dbg_sel,
  output logic [REG_W-1:0]  dbg_reg,
  output logic [DATA_W-1:0] dbg_d,
  output logic              dbg_df,
  output logic [SEL_W-1:0]  dbg_p,
  output logic [SEL_W-1:0]  dbg_x,
  output logic              mc_end,
  output logic              halted
);

  logic [DATA_W-1:0] d_q, bus_q, ir_q;
  logic              df_q;
  logic [SEL_W-1:0]  p_q, x_q;

  logic phase_first, phase_cap, phase_last, in_fetch, in_exec;
  logic fetch_last, exec_last;

  logic [DATA_W-1:0] op_now;
  op_kind_e          kind;
  logic              needs_imm;

  logic              rf_we;
  logic [SEL_W-1:0]  rf_waddr;
  logic [REG_W-1:0]  rf_wdata;
  logic [REG_W-1:0]  pc_val, rn_val;
  logic [SEL_W-1:0]  n_sel;
  logic [DATA_W:0]   diff;

  // Opcode decode uses the fresh bus byte during fetch and the latched one during execute.
  assign op_now = in_fetch ? bus_q : ir_q;
  assign n_sel  = ir_q[SEL_W-1:0];

  regsel_decode u_dec (
    .opcode    (op_now),
    .kind      (kind),
    .needs_imm (needs_imm)
  );

  regsel_seq #(
    .CLKS_PER_MC (CLKS_PER_MC),
    .CAP_PHASE   (1)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .stop        (kind == K_BAD),
    .phase_first (phase_first),
    .phase_cap   (phase_cap),
    .phase_last  (phase_last),
    .in_fetch    (in_fetch),
    .in_exec     (in_exec),
    .halted      (halted)
  );

  assign fetch_last = phase_last && in_fetch;
  assign exec_last  = phase_last && in_exec;

  regsel_regfile #(
    .NREG  (NREG),
    .REG_W (REG_W)
  ) u_rf (
    .clk       (clk),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .raddr_a   (p_q),
    .raddr_b   (n_sel),
    .raddr_dbg (dbg_sel),
    .rdata_a   (pc_val),
    .rdata_b   (rn_val),
    .rdata_dbg (dbg_reg)
  );

  assign diff = {1'b0, d_q} - {1'b0, bus_q};

  // One write port: reset clear of register 0, program-counter advance, or byte insert.
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = p_q;
    rf_wdata = pc_val + 1'b1;
    if (rst) begin
      rf_we    = 1'b1;
      rf_waddr = '0;
      rf_wdata = '0;
    end else if (fetch_last) begin
      rf_we = 1'b1;
    end else if (exec_last) begin
      unique case (kind)
        K_PHI: begin
          rf_we    = 1'b1;
          rf_waddr = n_sel;
          rf_wdata = {d_q, rn_val[DATA_W-1:0]};
        end
        K_PLO: begin
          rf_we    = 1'b1;
          rf_waddr = n_sel;
          rf_wdata = {rn_val[REG_W-1:DATA_W], d_q};
        end
        K_LDI, K_SMI: rf_we = 1'b1;
        default: rf_we = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q   <= '0;
      df_q  <= 1'b0;
      p_q   <= '0;
      x_q   <= '0;
      ir_q  <= '0;
      bus_q <= '0;
    end else begin
      if (phase_cap) bus_q <= mem_rdata;
      if (fetch_last) ir_q <= bus_q;
      if (exec_last) begin
        unique case (kind)
          K_GHI: d_q <= rn_val[REG_W-1:DATA_W];
          K_LDI: d_q <= bus_q;
          K_SMI: begin
            d_q  <= diff[DATA_W-1:0];
            df_q <= ~diff[DATA_W];
          end
          K_SEP: p_q <= n_sel;
          default: ;
        endcase
      end
    end
  end

  assign mem_addr  = pc_val;
  assign mem_rd_en = phase_first && (in_fetch || (in_exec && needs_imm));
  assign mc_end    = phase_last;
  assign dbg_d     = d_q;
  assign dbg_df    = df_q;
  assign dbg_p     = p_q;
  assign dbg_x     = x_q;

endmodule

// File: rtl/regsel_core_chk.sv
module regsel_core_chk #(
  parameter int CLKS_PER_MC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_rd_en,
  input logic        mc_end,
  input logic        halted,
  input logic [3:0]  dbg_p,
  input logic [3:0]  dbg_x,
  input logic [7:0]  dbg_d,
  input logic [15:0] pc_val,
  input logic        fetch_last
);

  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || mc_end) gap_q <= '0;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbg_p == 4'd0 && dbg_x == 4'd0 && !halted && mem_rd_en));

  p_mc_length_r2: assert property (@(posedge clk) disable iff (rst)
    mc_end |-> (gap_q == 8'(CLKS_PER_MC - 1)));

  p_read_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    fetch_last |=> (pc_val == $past(pc_val) + 16'd1));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd_en && !mc_end));

  p_halt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (halted && $past(halted)) |-> ($stable(dbg_d) && $stable(dbg_p) && $stable(pc_val)));

endmodule

bind regsel_core regsel_core_chk #(.CLKS_PER_MC(CLKS_PER_MC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_rd_en  (mem_rd_en),
  .mc_end     (mc_end),
  .halted     (halted),
  .dbg_p      (dbg_p),
  .dbg_x      (dbg_x),
  .dbg_d      (dbg_d),
  .pc_val     (pc_val),
  .fetch_last (fetch_last)
);

// File: tb/regsel_core_bench.sv
module regsel_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rdata = 8'h00;
  logic [3:0]  dbg_sel = 4'd0;
  logic [15:0] dbg_reg;
  logic [7:0]  dbg_d;
  logic        dbg_df;
  logic [3:0]  dbg_p, dbg_x;
  logic        mc_end, halted;

  always #4 clk = ~clk;

  regsel_core u_regsel_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_rdata (mem_rdata),
    .dbg_sel   (dbg_sel),
    .dbg_reg   (dbg_reg),
    .dbg_d     (dbg_d),
    .dbg_df    (dbg_df),
    .dbg_p     (dbg_p),
    .dbg_x     (dbg_x),
    .mc_end    (mc_end),
    .halted    (halted)
  );

  // 256-byte memory, mirrored across the 16-bit address space.
  logic [7:0] mem [256];
  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];

  int n_tests = 0;
  int n_fail  = 0;
  int run_clks, run_mcs, rd_n;
  logic [15:0] rd_addr [16];
  int          rd_clk  [16];
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_prog(input int limit);
    do_reset();
    run_clks = 0; run_mcs = 0; rd_n = 0;
    while (!halted && run_clks < limit) begin
      if (mem_rd_en && rd_n < 16) begin
        rd_addr[rd_n] = mem_addr;
        rd_clk[rd_n]  = run_clks;
        rd_n++;
      end
      if (mc_end) run_mcs++;
      @(negedge clk);
      run_clks++;
    end
  endtask

  task automatic peek(input logic [3:0] s, output logic [15:0] v);
    dbg_sel = s;
    @(negedge clk);
    v = dbg_reg;
  endtask

  // 20-instruction start-up routine, then an unsupported opcode at the address R4 selects.
  task automatic t_init_routine();
    logic [15:0] v;
    clear_mem();
    put(8'h00, 8'hF8); put(8'h01, 8'h7F); put(8'h02, 8'hB1);
    put(8'h03, 8'hF8); put(8'h04, 8'hFF); put(8'h05, 8'hA1);
    put(8'h06, 8'h91); put(8'h07, 8'hBB);
    put(8'h08, 8'hFF); put(8'h09, 8'h01);
    put(8'h0A, 8'hB2); put(8'h0B, 8'hB6);
    put(8'h0C, 8'hF8); put(8'h0D, 8'hA0); put(8'h0E, 8'hA2);
    put(8'h0F, 8'hFF); put(8'h10, 8'hB0); put(8'h11, 8'hA6);
    put(8'h12, 8'h90); put(8'h13, 8'hB4);
    put(8'h14, 8'hF8); put(8'h15, 8'h20); put(8'h16, 8'hA4);
    put(8'h17, 8'hF8); put(8'h18, 8'h03); put(8'h19, 8'hB5);
    put(8'h1A, 8'hD4);
    put(8'h1B, 8'hF8);
    run_prog(2000);
    chk_eq("R8 halted after routine", 16'(halted), 16'd1);
    chk_eq("R2 machine cycles 20 instr + bad fetch", 16'(run_mcs), 16'd41);
    chk_eq("R2 clocks to halt", 16'(run_clks), 16'd328);
    peek(4'd0, v); chk_eq("R3 R0 final", v, 16'h001B);
    peek(4'd1, v); chk_eq("R4 R1 PHI/PLO", v, 16'h7FFF);
    peek(4'd2, v); chk_eq("R4 R2 stack", v, 16'h7EA0);
    peek(4'd4, v); chk_eq("R7 R4 advanced after SEP fetch", v, 16'h0021);
    peek(4'd5, v); chk_eq("R4 R5 high byte", {8'h00, v[15:8]}, 16'h0003);
    peek(4'd6, v); chk_eq("R6 R6 borrow result", v, 16'h7EF0);
    peek(4'd11, v); chk_eq("R4 RB high byte", {8'h00, v[15:8]}, 16'h007F);
    chk_eq("R5 accumulator", {8'h00, dbg_d}, 16'h0003);
    chk_eq("R6 flag after borrow", 16'(dbg_df), 16'd0);
    chk_eq("R7 pointer now 4", {12'h0, dbg_p}, 16'h0004);
    chk_eq("R9 indirect pointer", {12'h0, dbg_x}, 16'h0000);
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    rst = 1'b1;
    @(negedge clk);
    chk_eq("R1 halted low in reset", 16'(halted), 16'd0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_eq("R1 first read strobe", 16'(mem_rd_en), 16'd1);
    chk_eq("R1 first address", mem_addr, 16'h0000);
    chk_eq("R1 P reset", {12'h0, dbg_p}, 16'h0000);
    chk_eq("R1 X reset", {12'h0, dbg_x}, 16'h0000);
    chk_eq("R1 D reset", {8'h00, dbg_d}, 16'h0000);
    chk_eq("R1 DF reset", 16'(dbg_df), 16'd0);
    peek(4'd0, v); chk_eq("R1 R0 cleared", v, 16'h0000);
  endtask

  task automatic t_read_timing();
    logic [15:0] v;
    clear_mem();
    put(0, 8'hF8); put(1, 8'h5A); put(2, 8'h90);
    run_prog(500);
    chk_eq("R2 read count", 16'(rd_n), 16'd4);
    chk_eq("R2 read0 clock", 16'(rd_clk[0]), 16'd0);
    chk_eq("R5 read1 clock imm", 16'(rd_clk[1]), 16'd8);
    chk_eq("R5 read1 addr imm", rd_addr[1], 16'h0001);
    chk_eq("R2 read2 clock", 16'(rd_clk[2]), 16'd16);
    chk_eq("R4 no read in GHI exec", 16'(rd_clk[3]), 16'd32);
    chk_eq("R3 read3 addr", rd_addr[3], 16'h0003);
    chk_eq("R2 halt clocks", 16'(run_clks), 16'd40);
    chk_eq("R4 GHI of R0 high", {8'h00, dbg_d}, 16'h0000);
    peek(4'd0, v); chk_eq("R3 R0 after run", v, 16'h0004);
  endtask

  task automatic t_sub(input logic [7:0] a, input logic [7:0] b, input logic [7:0] expd, input bit expf);
    clear_mem();
    put(0, 8'hF8); put(1, a); put(2, 8'hFF); put(3, b); put(4, 8'h68);
    run_prog(500);
    chk_eq("R6 difference", {8'h00, dbg_d}, {8'h00, expd});
    chk_eq("R6 flag", 16'(dbg_df), 16'(expf));
  endtask

  task automatic t_halt_quiet();
    logic [15:0] v0, v1;
    logic [7:0]  d0;
    bit          noisy;
    t_sub(8'h05, 8'h03, 8'h02, 1'b1);
    peek(4'd0, v0);
    d0 = dbg_d;
    noisy = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mem_rd_en || mc_end || !halted) noisy = 1'b1;
    end
    chk_eq("R8 silent while halted", 16'(noisy), 16'd0);
    chk_eq("R8 R0 after bad fetch", v0, 16'h0005);
    peek(4'd0, v1); chk_eq("R8 R0 frozen", v1, v0);
    chk_eq("R8 D frozen", {8'h00, dbg_d}, {8'h00, d0});
  endtask

  task automatic t_pc_wrap();
    logic [15:0] v;
    clear_mem();
    put(0, 8'hF8); put(1, 8'hFF); put(2, 8'hB3); put(3, 8'hA3);
    put(4, 8'hD3); put(8'hFF, 8'hD0); put(5, 8'h93);
    run_prog(1000);
    chk_eq("R3 wrap machine cycles", 16'(run_mcs), 16'd13);
    peek(4'd3, v); chk_eq("R3 R3 wrapped", v, 16'h0000);
    peek(4'd0, v); chk_eq("R7 R0 resumed", v, 16'h0007);
    chk_eq("R7 P back to 0", {12'h0, dbg_p}, 16'h0000);
    chk_eq("R4 GHI after wrap", {8'h00, dbg_d}, 16'h0000);
  endtask

  initial begin
    t_init_routine();
    t_reset_state();
    t_read_timing();
    t_sub(8'h07, 8'h07, 8'h00, 1'b1);
    t_sub(8'h02, 8'h03, 8'hFF, 1'b0);
    t_sub(8'hFF, 8'h00, 8'hFF, 1'b1);
    t_halt_quiet();
    t_pc_wrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule